// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a down-counting watchdog with a closed/open refresh window. A configuration byte is captured while system reset is held low. Its period field picks one of four start counts. Its window field picks how much of the end of each period will accept a refresh. Once reset is released, the counter loads the start count. It then decrements once per cycle in which the tick-enable input is high.

Software, or some other supervising agent, pulses the refresh strobe once per period. A strobe that lands in the open window reloads the counter with no penalty. A strobe that lands while the window is still closed is treated as a fault. If the counter runs past zero, or a refresh comes too early, the block pulses its watchdog-reset output for exactly one clock. It then starts a fresh period.

The controller is a five-state machine.
- `ST_LOAD` is held during reset. It loads the counter on the first cycle after release.
- `ST_CLOSED` means the remaining count is above the window threshold.
- `ST_OPEN` means the remaining count is at or below the threshold.
- `ST_ARMED` means a valid refresh has been seen and the reload waits for the next tick.
- `ST_FIRE` is the one-cycle reset pulse.

The transitions are as follows.
- LOAD→CLOSED/OPEN: the counter has been loaded.
- CLOSED→OPEN: a tick takes the count down into the window.
- CLOSED→FIRE: early refresh.
- OPEN→ARMED: refresh without a tick.
- OPEN→CLOSED/OPEN: refresh together with a tick reloads the counter at once.
- OPEN→FIRE: a tick at count zero.
- ARMED→CLOSED/OPEN: the pending reload is applied on a tick.
- FIRE→CLOSED/OPEN: the pulse cycle ends.

After a reload, the machine goes to OPEN only when the window is 100%, and to CLOSED otherwise.

Top module: `winwd_top`

## Requirements
- R1: Period field cfg_in[1:0] selects the start count: 0 → 0x03FF, 1 → 0x0FFF, 2 → 0x1FFF, 3 → 0x3FFF. After a reload, start+1 ticks pass before the underflow pulse.
- R2: Window field cfg_in[3:2] value w sets the threshold to floor(start·(w+1)/4), which gives 25/50/75/100%. A refresh is valid only when the remaining count is at or below this threshold.
- R3: A refresh while the remaining count is above the threshold drives wdt_rst high for the next cycle and reloads the counter.
- R4: A valid refresh never raises wdt_rst. The counter reloads on the first tick at or after the strobe, in the same cycle if tick_en is high then.
- R5: A tick at count zero with no refresh drives wdt_rst high for exactly one cycle and reloads the counter.
- R6: With tick_en low the count does not change, and no underflow can occur.
- R7: The configuration is captured only while rst_n is low. Later changes on cfg_in have no effect.
- R8: If cfg_in[7:4] is not 4'hF at capture, the byte is taken as 0xFF, which gives the 0x3FFF period and the 100% window.
- R9: wdt_rst is low while in reset and during the load cycle after release.
- R10: In the load cycle and in the wdt_rst pulse cycle, tick_en and refresh are ignored.
- R11: A refresh and a tick in the same cycle at count zero count as a valid refresh. No pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset; configuration is captured while low |
| cfg_in | input | 8 | Configuration byte: [1:0] period, [3:2] window, [7:4] must be all ones |
| tick_en | input | 1 | Count-enable tick |
| refresh | input | 1 | Single-cycle refresh strobe |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
Refresh acceptance and underflow detection can fall in the same cycle: a strobe and a tick arrive together while the count is zero. The bench reaches this by ticking a 0x03FF period down to exactly zero and then driving refresh and tick_en high together. The scoreboard model expects no pulse on the following cycle, and a full fresh period before the next underflow. The second collision tested is a strobe or tick that lands in the pulse cycle itself; the bench expects it to be dropped.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

    typedef enum logic [2:0] {
        ST_LOAD,
        ST_CLOSED,
        ST_OPEN,
        ST_ARMED,
        ST_FIRE
    } wd_state_e;

    typedef struct packed {
        logic [3:0] rsv;
        logic [1:0] win;
        logic [1:0] per;
    } wd_cfg_t;

    localparam logic [7:0] CFG_BLANK = 8'hFF;
    localparam logic [3:0] RSV_ONES  = 4'hF;

endpackage

// File: rtl/wdw_cfg.sv
module wdw_cfg
    import wdw_pkg::*;
#(
    parameter int              CNT_W = 14,
    parameter logic [CNT_W-1:0] PER0 = CNT_W'('h03FF),
    parameter logic [CNT_W-1:0] PER1 = CNT_W'('h0FFF),
    parameter logic [CNT_W-1:0] PER2 = CNT_W'('h1FFF),
    parameter logic [CNT_W-1:0] PER3 = CNT_W'('h3FFF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       cfg_raw,
    output wd_cfg_t          cfg_q,
    output logic [CNT_W-1:0] start,
    output logic [CNT_W-1:0] thr,
    output logic             full_win
);
    localparam int PW = CNT_W + 2;

    logic [PW-1:0] prod;

    // capture while reset is held; malformed bytes fall back to blank
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (cfg_raw[7:4] == RSV_ONES) cfg_q <= wd_cfg_t'(cfg_raw);
            else                          cfg_q <= wd_cfg_t'(CFG_BLANK);
        end
    end

    always_comb begin
        unique case (cfg_q.per)
            2'd0:    start = PER0;
            2'd1:    start = PER1;
            2'd2:    start = PER2;
            default: start = PER3;
        endcase
    end

    assign prod     = {2'b00, start} * (PW'(cfg_q.win) + PW'(1));
    assign thr      = prod[PW-1:2];
    assign full_win = (cfg_q.win == 2'b11);

endmodule

// File: rtl/wdw_counter.sv
module wdw_counter #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    input  logic [CNT_W-1:0] start,
    input  logic [CNT_W-1:0] thr,
    output logic [CNT_W-1:0] cnt,
    output logic             is_zero,
    output logic             early,
    output logic             win_next
);
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= start;
        else if (dec)  cnt <= cnt - CNT_W'(1);
    end

    assign is_zero  = (cnt == '0);
    assign early    = (cnt > thr);
    assign win_next = ((cnt - CNT_W'(1)) <= thr);

endmodule

// File: rtl/wdw_fsm.sv
module wdw_fsm
    import wdw_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_en,
    input  logic      refresh,
    input  logic      early,
    input  logic      is_zero,
    input  logic      win_next,
    input  logic      full_win,
    output logic      load,
    output logic      dec,
    output logic      fire,
    output wd_state_e st
);
    wd_state_e st_nx;
    wd_state_e home;

    assign home = full_win ? ST_OPEN : ST_CLOSED;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_LOAD;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        load  = 1'b0;
        dec   = 1'b0;
        unique case (st)
            ST_LOAD: begin
                load  = 1'b1;
                st_nx = home;
            end
            ST_FIRE: begin
                st_nx = home;
            end
            ST_CLOSED: begin
                if (refresh) begin
                    load  = 1'b1;
                    st_nx = ST_FIRE;
                end else if (tick_en) begin
                    dec = 1'b1;
                    if (win_next) st_nx = ST_OPEN;
                end
            end
            ST_OPEN: begin
                if (refresh && early) begin
                    load  = 1'b1;
                    st_nx = ST_FIRE;
                end else if (refresh && tick_en) begin
                    load  = 1'b1;
                    st_nx = home;
                end else if (refresh) begin
                    st_nx = ST_ARMED;
                end else if (tick_en) begin
                    if (is_zero) begin
                        load  = 1'b1;
                        st_nx = ST_FIRE;
                    end else begin
                        dec = 1'b1;
                    end
                end
            end
            ST_ARMED: begin
                if (tick_en) begin
                    load  = 1'b1;
                    st_nx = home;
                end
            end
            default: st_nx = ST_LOAD;
        endcase
    end

    always_comb fire = (st == ST_FIRE);

endmodule

// File: rtl/winwd_top.sv
module winwd_top
    import wdw_pkg::*;
#(
    parameter int              CNT_W = 14,
    parameter logic [CNT_W-1:0] PER0 = CNT_W'('h03FF),
    parameter logic [CNT_W-1:0] PER1 = CNT_W'('h0FFF),
    parameter logic [CNT_W-1:0] PER2 = CNT_W'('h1FFF),
    parameter logic [CNT_W-1:0] PER3 = CNT_W'('h3FFF)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] cfg_in,
    input  logic       tick_en,
    input  logic       refresh,
    output logic       wdt_rst
);
    wd_cfg_t          cfg_q;
    logic [CNT_W-1:0] start;
    logic [CNT_W-1:0] thr;
    logic [CNT_W-1:0] cnt;
    logic             full_win;
    logic             load;
    logic             dec;
    logic             is_zero;
    logic             early;
    logic             win_next;
    wd_state_e        st;

    wdw_cfg #(
        .CNT_W(CNT_W), .PER0(PER0), .PER1(PER1), .PER2(PER2), .PER3(PER3)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_raw(cfg_in),
        .cfg_q(cfg_q), .start(start), .thr(thr), .full_win(full_win)
    );

    wdw_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .dec(dec),
        .start(start), .thr(thr), .cnt(cnt),
        .is_zero(is_zero), .early(early), .win_next(win_next)
    );

    wdw_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .refresh(refresh),
        .early(early), .is_zero(is_zero), .win_next(win_next),
        .full_win(full_win), .load(load), .dec(dec), .fire(wdt_rst), .st(st)
    );

endmodule

// File: rtl/winwd_chk.sv
module winwd_chk
    import wdw_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             refresh,
    input logic             wdt_rst,
    input wd_state_e        st,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] start,
    input logic [CNT_W-1:0] thr,
    input wd_cfg_t          cfg_q
);
    logic running;
    assign running = (st == ST_CLOSED) || (st == ST_OPEN) || (st == ST_ARMED);

    AST_EARLY_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh && running && cnt > thr) |=> wdt_rst);                      // R3

    AST_RELOAD_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |-> (cnt == start));                                         // R3

    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> !wdt_rst);                                               // R5

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !refresh && running) |=> $stable(cnt));                 // R6

    AST_SILENT_NO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !refresh) |=> !wdt_rst);                                // R6

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg_q));                                    // R7

    AST_RSV_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.rsv == RSV_ONES);                                              // R8

    AST_ZERO_REFRESH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && refresh && st == ST_OPEN && cnt == '0) |=> !wdt_rst);    // R11

endmodule

bind winwd_top winwd_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .refresh(refresh),
    .wdt_rst(wdt_rst), .st(st), .cnt(cnt), .start(start), .thr(thr),
    .cfg_q(cfg_q)
);

// File: tb/sim_winwd_top.sv
module sim_winwd_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_in = 8'hFF;
    logic       tick_en = 1'b0;
    logic       refresh = 1'b0;
    logic       wdt_rst;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    bit    q_exp[$];
    string q_tag[$];

    int m_cnt, m_start, m_thr;
    bit m_pend, m_fire, m_first;

    always #5 clk = ~clk;

    winwd_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_in(cfg_in),
        .tick_en(tick_en), .refresh(refresh), .wdt_rst(wdt_rst)
    );

    // monitor: compare each expected pulse value just after the edge
    always @(posedge clk) begin
        #2;
        if (q_exp.size() > 0) begin
            bit    e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            n_chk++;
            if (wdt_rst !== e) begin
                n_err++;
                $display("FAIL %s: wdt_rst=%0b expected %0b at %0t", t, wdt_rst, e, $time);
            end
        end
    end

    task automatic set_model(input logic [7:0] c);
        logic [7:0] s;
        s = (c[7:4] == 4'hF) ? c : 8'hFF;
        case (s[1:0])
            2'd0: m_start = 'h03FF;
            2'd1: m_start = 'h0FFF;
            2'd2: m_start = 'h1FFF;
            default: m_start = 'h3FFF;
        endcase
        m_thr   = (m_start * (int'(s[3:2]) + 1)) / 4;
        m_first = 1'b1;
        m_pend  = 1'b0;
        m_fire  = 1'b0;
    endtask

    // driver: apply inputs at a falling edge, predict, push, wait one cycle
    task automatic drive(input bit k, input bit t, input string tag);
        refresh = k;
        tick_en = t;
        if (m_first) begin
            m_first = 1'b0; m_cnt = m_start;
        end else if (m_fire) begin
            m_fire = 1'b0;
        end else if (k && m_cnt > m_thr) begin
            m_fire = 1'b1; m_cnt = m_start; m_pend = 1'b0;
        end else if ((k || m_pend) && t) begin
            m_cnt = m_start; m_pend = 1'b0;
        end else if (k) begin
            m_pend = 1'b1;
        end else if (t) begin
            if (m_cnt == 0) begin
                m_fire = 1'b1; m_cnt = m_start;
            end else begin
                m_cnt = m_cnt - 1;
            end
        end
        q_exp.push_back(m_fire);
        q_tag.push_back(tag);
        @(negedge clk);
    endtask

    task automatic run(input int n, input bit k, input bit t, input string tag);
        for (int i = 0; i < n; i++) drive(k, t, tag);
    endtask

    task automatic do_reset(input logic [7:0] c);
        rst_n   = 1'b0;
        refresh = 1'b0;
        tick_en = 1'b0;
        cfg_in  = c;
        repeat (3) @(negedge clk);
        n_chk++;
        if (wdt_rst !== 1'b0) begin
            n_err++;
            $display("FAIL R9: wdt_rst=%0b expected 0 in reset", wdt_rst);
        end
        set_model(c);
        rst_n = 1'b1;
        drive(1'b1, 1'b1, "R10");   // load cycle ignores both inputs (R9 too)
    endtask

    initial begin
        @(negedge clk);

        // R8: reserved bits broken -> blank config, 0x3FFF / 100%
        do_reset(8'h00);
        drive(1'b1, 1'b0, "R8");          // in window only if treated as 0xFF
        run(16'h4001, 1'b0, 1'b1, "R1");  // pending reload, then full period

        // 0x03FF period, 25% window
        do_reset(8'hF0);
        run(5, 1'b0, 1'b1, "R6");
        drive(1'b1, 1'b0, "R3");          // early refresh
        drive(1'b1, 1'b1, "R10");         // pulse cycle ignores inputs
        run(16'h02FF, 1'b0, 1'b1, "R2");  // count reaches 0x100
        drive(1'b1, 1'b0, "R2");          // one above threshold
        drive(1'b0, 1'b0, "R10");
        run(16'h0300, 1'b0, 1'b1, "R2");  // count reaches 0xFF
        drive(1'b1, 1'b0, "R4");          // valid, waits for tick
        run(20, 1'b0, 1'b0, "R6");
        drive(1'b0, 1'b1, "R4");          // pending reload applied
        run(16'h0400, 1'b0, 1'b1, "R5");  // underflow pulse
        drive(1'b0, 1'b1, "R10");
        run(16'h03FF, 1'b0, 1'b1, "R5");  // count reaches zero
        run(50, 1'b0, 1'b0, "R6");        // no tick, no underflow
        drive(1'b1, 1'b1, "R11");         // refresh + tick at zero
        cfg_in = 8'h00;                   // ignored after reset
        run(16'h0401, 1'b0, 1'b1, "R7");
        drive(1'b0, 1'b0, "R5");

        // 0x0FFF period, 50% window
        do_reset(8'hF5);
        run(16'h07FF, 1'b0, 1'b1, "R2");
        drive(1'b1, 1'b0, "R2");          // count 0x800 is closed
        drive(1'b0, 1'b0, "R10");
        run(16'h0800, 1'b0, 1'b1, "R2");
        drive(1'b1, 1'b1, "R4");          // count 0x7FF: accepted, reload now
        run(16'h1001, 1'b0, 1'b1, "R1");

        // 0x1FFF period, 75% window
        do_reset(8'hFA);
        run(16'h07FF, 1'b0, 1'b1, "R2");
        drive(1'b1, 1'b0, "R2");
        drive(1'b0, 1'b0, "R10");
        run(16'h0800, 1'b0, 1'b1, "R2");
        drive(1'b1, 1'b1, "R4");
        run(16'h2001, 1'b0, 1'b1, "R1");
        drive(1'b0, 1'b0, "R5");

        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule